// File: doc/BRIEF.md
# Clock Synthesizer Operating-Mode Sequencer

This block sits beside one synthesis loop and decides which operating mode that loop is in. After a hard reset it waits in an initialization mode. It then runs free from the local reference. When the chosen input clock is valid it starts acquiring lock, and it declares lock once the phase detector reports it. When the chosen input fails, it either falls back or asks for a different input. Software can also hold the loop off its input on demand with a force bit.

When the selected input fails, the block first checks whether any other input is valid. If one is, it raises a switch request so the external selector can pick a new input, and it keeps acquiring. If none is valid, it enters holdover when averaged history is valid, and otherwise it returns to free-run. A status bit reports that the loop is not synchronized to any input. A sticky flag records each entry into holdover and is cleared by a software write of zero. Unless masked, the sticky flag drives an active-low interrupt contribution.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pll_mode_seq`

## Requirements
- R1: While `rst_n` is low, the block is in the initialization state. In that state `mode` is 0, and `hold_stat`, `hold_sticky` and `switch_req` are 0 while `irq_n` is 1. Mode codes are: 0 init, 1 free-run, 2 acquire, 3 locked, 4 holdover.
- R2: The block stays in init (0) while `init_done` is low. It moves to free-run (1) at the first rising edge with `init_done` high.
- R3: From free-run, the block goes to acquire (2) at the next edge if `force_hold` is low and input `sel_idx` has its `in_valid` bit set.
- R4: From acquire, the block goes to locked (3) at the next edge if `phase_locked` is high, the selected input is valid and `force_hold` is low.
- R5: Take any non-init mode with `force_hold` low, the selected input invalid and some other input valid. Then `switch_req` is 1 in the following cycle, and acquire or locked becomes acquire.
- R6: In acquire or locked, if the selected input is invalid, no other input is valid and `force_hold` is low, the next mode is holdover (4) when `hist_valid` is 1 and free-run (1) when it is 0.
- R7: From holdover, the block goes to acquire at the next edge when `force_hold` is low and the selected input is valid.
- R8: `force_hold` high in acquire or locked gives holdover at the next edge, and holdover persists while the bit stays high. Clearing the bit with the selected input valid gives acquire.
- R9: `hold_stat` is 1 exactly when `mode` is free-run or holdover.
- R10: `hold_sticky` becomes 1 on the same edge that `mode` enters holdover. A write strobe `sticky_wr` with `sticky_wdata` 0 clears it at the next edge. A write with data 1 leaves it unchanged.
- R11: If a clearing write and an entry into holdover happen in the same cycle, `hold_sticky` stays 1.
- R12: `irq_n` is 0 exactly when `hold_sticky` is 1 and `irq_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| init_done | input | 1 | Initialization finished |
| in_valid | input | NUM_IN | Per-input valid flags |
| sel_idx | input | SEL_W | Currently selected input |
| phase_locked | input | 1 | Phase lock achieved |
| hist_valid | input | 1 | Averaged holdover history usable |
| force_hold | input | 1 | Force holdover |
| sticky_wr | input | 1 | Write strobe for the sticky flag |
| sticky_wdata | input | 1 | Write data; 0 clears |
| irq_mask | input | 1 | 1 masks the interrupt |
| mode | output | 3 | Current mode code |
| hold_stat | output | 1 | Not synchronized to an input |
| hold_sticky | output | 1 | Sticky holdover-entry flag |
| irq_n | output | 1 | Active-low interrupt contribution |
| switch_req | output | 1 | Request for another input |

## Verification
The hardest case to reach is a clearing write that lands in the very cycle the machine enters holdover. The stimulus first drives the loop to locked and clears any earlier flag. It then raises `force_hold` and the zero-write strobe on the same falling edge, so both are seen at one rising edge. Input failover is reached in a similar way. Two inputs are made valid while locked, then the selected one is dropped, so the fault arrives with a spare input present.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT = 3'd0,
    M_FREE = 3'd1,
    M_ACQ  = 3'd2,
    M_LOCK = 3'd3,
    M_HOLD = 3'd4
  } mode_e;
endpackage

// File: rtl/pll_input_eval.sv
module pll_input_eval #(
  parameter int NUM_IN = 4,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_IN-1:0] in_valid,
  input  logic [SEL_W-1:0]  sel_idx,
  output logic              sel_ok,
  output logic              other_ok
);
  logic [NUM_IN-1:0] hit;
  logic [NUM_IN-1:0] spare;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign hit[i]   = in_valid[i] && (sel_idx == SEL_W'(i));
    assign spare[i] = in_valid[i] && (sel_idx != SEL_W'(i));
  end

  assign sel_ok   = |hit;
  assign other_ok = |spare;
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_done,
  input  logic  sel_ok,
  input  logic  other_ok,
  input  logic  phase_locked,
  input  logic  hist_valid,
  input  logic  force_hold,
  output mode_e state,
  output logic  hold_entry,
  output logic  switch_req
);
  mode_e nxt;
  logic  fault;
  logic  fail_over;

  assign fault     = !force_hold && !sel_ok;
  assign fail_over = fault && other_ok;

  always_comb begin
    nxt = state;
    unique case (state)
      M_INIT: if (init_done) nxt = M_FREE;
      M_FREE: if (!force_hold && sel_ok) nxt = M_ACQ;
      M_ACQ, M_LOCK: begin
        if (force_hold)      nxt = M_HOLD;
        else if (fail_over)  nxt = M_ACQ;
        else if (fault)      nxt = hist_valid ? M_HOLD : M_FREE;
        else if (state == M_ACQ && phase_locked) nxt = M_LOCK;
      end
      M_HOLD: if (!force_hold && sel_ok) nxt = M_ACQ;
      default: nxt = M_INIT;
    endcase
  end

  assign hold_entry = (nxt == M_HOLD) && (state != M_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= M_INIT;
      switch_req <= 1'b0;
    end else begin
      state      <= nxt;
      switch_req <= (state != M_INIT) && fail_over;
    end
  end

  // R2
  init_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_INIT && !init_done) |=> state == M_INIT);
  // R8
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == M_ACQ || state == M_LOCK) && force_hold) |=> state == M_HOLD);
  // R6
  hist_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_LOCK && !force_hold && !sel_ok && !other_ok && hist_valid)
      |=> state == M_HOLD);
  // R5
  failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_LOCK && !force_hold && !sel_ok && other_ok)
      |=> (switch_req && state == M_ACQ));
endmodule

// File: rtl/pll_hold_flag.sv
module pll_hold_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_entry,
  input  logic sticky_wr,
  input  logic sticky_wdata,
  input  logic irq_mask,
  output logic hold_sticky,
  output logic irq_n
);
  logic clr;
  assign clr = sticky_wr && !sticky_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_sticky <= 1'b0;
    else        hold_sticky <= (hold_sticky && !clr) || hold_entry;
  end

  assign irq_n = !(hold_sticky && !irq_mask);

  // R11
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_entry && clr) |=> hold_sticky);
  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_sticky && !clr) |=> hold_sticky);
  // R10
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold_entry) |=> !hold_sticky);
endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq
  import pll_mode_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [NUM_IN-1:0] in_valid,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic              phase_locked,
  input  logic              hist_valid,
  input  logic              force_hold,
  input  logic              sticky_wr,
  input  logic              sticky_wdata,
  input  logic              irq_mask,
  output logic [2:0]        mode,
  output logic              hold_stat,
  output logic              hold_sticky,
  output logic              irq_n,
  output logic              switch_req
);
  logic  sel_ok, other_ok, hold_entry;
  mode_e state;

  pll_input_eval #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_eval (
    .in_valid(in_valid), .sel_idx(sel_idx),
    .sel_ok(sel_ok), .other_ok(other_ok)
  );

  pll_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .sel_ok(sel_ok), .other_ok(other_ok), .phase_locked(phase_locked),
    .hist_valid(hist_valid), .force_hold(force_hold),
    .state(state), .hold_entry(hold_entry), .switch_req(switch_req)
  );

  pll_hold_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hold_entry(hold_entry),
    .sticky_wr(sticky_wr), .sticky_wdata(sticky_wdata),
    .irq_mask(irq_mask), .hold_sticky(hold_sticky), .irq_n(irq_n)
  );

  assign mode      = state;
  assign hold_stat = (state == M_FREE) || (state == M_HOLD);

  // R9
  stat_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_sticky) |-> (hold_stat && mode == 3'd4));
endmodule

// File: tb/pll_mode_seq_bench.sv
module pll_mode_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 4;

  logic clk = 0, rst_n = 0;
  logic init_done = 0, phase_locked = 0, hist_valid = 0, force_hold = 0;
  logic sticky_wr = 0, sticky_wdata = 0, irq_mask = 0;
  logic [NIN-1:0] in_valid = '0;
  logic [1:0] sel_idx = '0;
  logic [2:0] mode;
  logic hold_stat, hold_sticky, irq_n, switch_req;

  int checks = 0, fails = 0, wd = 0;
  bit done = 0;

  int  m_mode = 0;
  bit  m_sticky = 0, m_sw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_mode_seq #(.NUM_IN(NIN)) u_pll_mode_seq (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .in_valid(in_valid),
    .sel_idx(sel_idx), .phase_locked(phase_locked), .hist_valid(hist_valid),
    .force_hold(force_hold), .sticky_wr(sticky_wr), .sticky_wdata(sticky_wdata),
    .irq_mask(irq_mask), .mode(mode), .hold_stat(hold_stat),
    .hold_sticky(hold_sticky), .irq_n(irq_n), .switch_req(switch_req)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sticky = 0; m_sw = 0;
    end else begin
      bit cur_ok, spare;
      int nm;
      cur_ok = in_valid[sel_idx];
      spare = 0;
      for (int i = 0; i < NIN; i++) if (i != sel_idx && in_valid[i]) spare = 1;
      nm = m_mode;
      if (m_mode == 0) begin
        if (init_done) nm = 1;
      end else if (m_mode == 1 || m_mode == 4) begin
        if (!force_hold && cur_ok) nm = 2;
      end else begin
        if (force_hold) nm = 4;
        else if (!cur_ok && spare) nm = 2;
        else if (!cur_ok) nm = hist_valid ? 4 : 1;
        else if (m_mode == 2 && phase_locked) nm = 3;
      end
      m_sw = (m_mode != 0) && !force_hold && !cur_ok && spare;
      if (sticky_wr && !sticky_wdata) m_sticky = 0;
      if (nm == 4 && m_mode != 4) m_sticky = 1;
      m_mode = nm;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("model mode", mode, m_mode);
    chk("model R9 hold_stat", hold_stat, (m_mode == 1 || m_mode == 4));
    chk("model R10 sticky", hold_sticky, m_sticky);
    chk("model R12 irq_n", irq_n, !(m_sticky && !irq_mask));
    chk("model R5 switch_req", switch_req, m_sw);
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<5000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 mode", mode, 0); chk("R1 hold_stat", hold_stat, 0);
    chk("R1 sticky", hold_sticky, 0); chk("R1 irq_n", irq_n, 1);
    chk("R1 switch_req", switch_req, 0);
    rst_n = 1;
    tick(); tick(); tick();
    chk("R2 wait", mode, 0);
    init_done = 1; tick();
    chk("R2 free", mode, 1); chk("R9 free", hold_stat, 1);
    in_valid = 4'b0001; sel_idx = 0; tick();
    chk("R3 acq", mode, 2); chk("R9 acq", hold_stat, 0);
    phase_locked = 1; tick();
    chk("R4 lock", mode, 3);
    in_valid = 4'b0101; tick();
    chk("R4 stays locked", mode, 3);
    in_valid = 4'b0100; tick();
    chk("R5 switch_req", switch_req, 1); chk("R5 mode", mode, 2);
    sel_idx = 2; tick();
    chk("R5 relock", mode, 3); chk("R5 req drop", switch_req, 0);
    hist_valid = 1; in_valid = 4'b0000; tick();
    chk("R6 hold", mode, 4); chk("R10 set", hold_sticky, 1);
    chk("R12 irq low", irq_n, 0); chk("R9 hold", hold_stat, 1);
    irq_mask = 1; tick();
    chk("R12 masked", irq_n, 1);
    irq_mask = 0; sticky_wr = 1; sticky_wdata = 1; tick();
    chk("R10 write one ignored", hold_sticky, 1);
    sticky_wdata = 0; tick();
    sticky_wr = 0;
    chk("R10 cleared", hold_sticky, 0); chk("R12 irq high", irq_n, 1);
    in_valid = 4'b0100; tick();
    chk("R7 exit hold", mode, 2);
    tick();
    chk("R4 lock again", mode, 3);
    hist_valid = 0; in_valid = 4'b0000; tick();
    chk("R6 free", mode, 1); chk("R6 no sticky", hold_sticky, 0);
    in_valid = 4'b0100; tick(); tick();
    chk("R4 lock third", mode, 3);
    force_hold = 1; tick();
    chk("R8 forced", mode, 4);
    tick();
    chk("R8 held", mode, 4);
    force_hold = 0; tick();
    chk("R8 release", mode, 2);
    tick();
    sticky_wr = 1; sticky_wdata = 0; tick();
    sticky_wr = 0;
    chk("R10 clear before race", hold_sticky, 0);
    force_hold = 1; sticky_wr = 1; sticky_wdata = 0; tick();
    sticky_wr = 0; force_hold = 0;
    chk("R11 race keeps set", hold_sticky, 1); chk("R11 mode", mode, 4);
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule